// File: doc/BRIEF.md
# Two-Master Crossbar Bus Arbiter

This block sits between two bus masters and two downstream bus channels. Each master presents a request together with an address, write data and a control group. A 2×2 crossbar steers each master's whole bus (address, data and control together) onto one of the two channels. A small control section decides the routing and issues a grant to each master.

The target slave of a request is the most significant address bit. Channel k always leads to slave k, so a granted master is steered onto the channel that matches its slave. When the two masters aim at different slaves, both are granted on the same edge and run in parallel, crossed or straight. When they aim at the same slave, only one is granted. The masters take turns over successive collisions, and the other master waits until the winner drops its request.

The crossbar does not change any signal. A channel carries exactly the bus of the master steered onto it. Routing and grants are registered, while the data path is combinational.

Top module: `dual_xbar_arb`

## Requirements
- R1: After reset both grants are low and the switch-select is 0 (straight: master 0 on channel 0, master 1 on channel 1).
- R2: A request's slave index is its address MSB. A granted master is routed onto the channel equal to its slave index. Switch-select 1 means crossed: master 0 on channel 1 and master 1 on channel 0.
- R3: Each channel's address, data and control outputs equal those of the master steered onto it. The channel's valid output equals that master's grant.
- R4: If both masters request different slaves while neither is granted, both grants rise on the clock edge after the requests appear.
- R5: If both masters newly request the same slave, only one is granted. Master 0 wins the first such collision after reset, and the loser of each collision wins the next one.
- R6: A grant stays high while its master keeps requesting, and the switch-select does not change while any grant is held.
- R7: A master blocked by a held grant on its slave is granted on the edge where the holder's request is first seen low.
- R8: A grant rises only if its master was requesting in the previous cycle.
- R9: While one master holds a grant, a new request from the other master for the other slave is granted on the next edge without changing the routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m0_req | input | 1 | Master 0 request |
| m0_addr | input | AW | Master 0 address |
| m0_wdata | input | DW | Master 0 write data |
| m0_ctrl | input | CW | Master 0 control group |
| m1_req | input | 1 | Master 1 request |
| m1_addr | input | AW | Master 1 address |
| m1_wdata | input | DW | Master 1 write data |
| m1_ctrl | input | CW | Master 1 control group |
| ch0_vld | output | 1 | Channel 0 carries a granted master |
| ch0_addr | output | AW | Channel 0 address |
| ch0_data | output | DW | Channel 0 data |
| ch0_ctrl | output | CW | Channel 0 control |
| ch1_vld | output | 1 | Channel 1 carries a granted master |
| ch1_addr | output | AW | Channel 1 address |
| ch1_data | output | DW | Channel 1 data |
| ch1_ctrl | output | CW | Channel 1 control |
| m0_gnt | output | 1 | Grant to master 0 |
| m1_gnt | output | 1 | Grant to master 1 |
| sw_sel | output | 1 | Crossbar routing, 0 straight, 1 crossed |

## Verification
The assertions check four things on every cycle:
- A grant never appears without a prior request.
- A grant and the routing stay fixed while a transaction continues.
- A newly granted master lands on the channel of its slave.
- Two grants never coexist on the same slave.

The bench scenarios show the remaining behaviour:
- The reset routing.
- Parallel service in crossed and straight form.
- The alternation of winners across repeated collisions.
- The hand-over edge to a blocked master.
- The field-by-field transparency of the data path.

// File: rtl/dual_xbar_arb.sv
module dual_xbar_arb #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m0_req,
  input  logic [AW-1:0] m0_addr,
  input  logic [DW-1:0] m0_wdata,
  input  logic [CW-1:0] m0_ctrl,
  input  logic          m1_req,
  input  logic [AW-1:0] m1_addr,
  input  logic [DW-1:0] m1_wdata,
  input  logic [CW-1:0] m1_ctrl,
  output logic          ch0_vld,
  output logic [AW-1:0] ch0_addr,
  output logic [DW-1:0] ch0_data,
  output logic [CW-1:0] ch0_ctrl,
  output logic          ch1_vld,
  output logic [AW-1:0] ch1_addr,
  output logic [DW-1:0] ch1_data,
  output logic [CW-1:0] ch1_ctrl,
  output logic          m0_gnt,
  output logic          m1_gnt,
  output logic          sw_sel
);
  localparam int MSB = AW - 1;

  logic g0, g1, sw, pri;
  logic s0, s1, keep0, keep1, c0, c1, blk0, blk1, col;
  logic ng0, ng1, nsw;

  assign s0    = m0_addr[MSB];
  assign s1    = m1_addr[MSB];
  assign keep0 = g0 & m0_req;
  assign keep1 = g1 & m1_req;
  assign c0    = m0_req & ~g0;
  assign c1    = m1_req & ~g1;
  // held slave of master 0 is sw, of master 1 is ~sw
  assign blk0  = keep1 & (s0 == ~sw);
  assign blk1  = keep0 & (s1 == sw);
  assign col   = c0 & c1 & (s0 == s1) & ~blk0 & ~blk1;

  assign ng0 = keep0 | (c0 & ~blk0 & ~(col & pri));
  assign ng1 = keep1 | (c1 & ~blk1 & ~(col & ~pri));

  always_comb begin
    if (keep0 | keep1) nsw = sw;
    else if (ng0)      nsw = s0;
    else if (ng1)      nsw = ~s1;
    else               nsw = sw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g0  <= 1'b0;
      g1  <= 1'b0;
      sw  <= 1'b0;
      pri <= 1'b0;
    end else begin
      g0 <= ng0;
      g1 <= ng1;
      sw <= nsw;
      if (col) pri <= ~pri;
    end
  end

  assign m0_gnt   = g0;
  assign m1_gnt   = g1;
  assign sw_sel   = sw;

  assign ch0_vld  = sw ? g1 : g0;
  assign ch0_addr = sw ? m1_addr  : m0_addr;
  assign ch0_data = sw ? m1_wdata : m0_wdata;
  assign ch0_ctrl = sw ? m1_ctrl  : m0_ctrl;
  assign ch1_vld  = sw ? g0 : g1;
  assign ch1_addr = sw ? m0_addr  : m1_addr;
  assign ch1_data = sw ? m0_wdata : m1_wdata;
  assign ch1_ctrl = sw ? m0_ctrl  : m1_ctrl;
endmodule

// File: rtl/dual_xbar_arb_chk.sv
module dual_xbar_arb_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m0_req,
  input logic          m1_req,
  input logic [AW-1:0] m0_addr,
  input logic [AW-1:0] m1_addr,
  input logic          m0_gnt,
  input logic          m1_gnt,
  input logic          sw_sel
);
  AST_GNT0_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(m0_gnt) |-> $past(m0_req)); // R8
  AST_GNT1_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(m1_gnt) |-> $past(m1_req)); // R8
  AST_HOLD_GNT0: assert property (@(posedge clk) disable iff (!rst_n) (m0_gnt && m0_req) |=> m0_gnt); // R6
  AST_HOLD_GNT1: assert property (@(posedge clk) disable iff (!rst_n) (m1_gnt && m1_req) |=> m1_gnt); // R6
  AST_HOLD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) ((m0_gnt && m0_req) || (m1_gnt && m1_req)) |=> $stable(sw_sel)); // R6
  AST_ROUTE_M0: assert property (@(posedge clk) disable iff (!rst_n) $rose(m0_gnt) |-> (sw_sel == m0_addr[AW-1])); // R2
  AST_ROUTE_M1: assert property (@(posedge clk) disable iff (!rst_n) $rose(m1_gnt) |-> (sw_sel != m1_addr[AW-1])); // R2
  AST_NO_SHARED_SLAVE: assert property (@(posedge clk) disable iff (!rst_n) (m0_gnt && m1_gnt && m0_req && m1_req) |-> (m0_addr[AW-1] != m1_addr[AW-1])); // R5
endmodule

bind dual_xbar_arb dual_xbar_arb_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m0_req(m0_req), .m1_req(m1_req),
  .m0_addr(m0_addr), .m1_addr(m1_addr), .m0_gnt(m0_gnt), .m1_gnt(m1_gnt),
  .sw_sel(sw_sel)
);

// File: tb/tb_dual_xbar_arb.sv
module tb_dual_xbar_arb;
  localparam int AW = 32, DW = 32, CW = 4;
  localparam logic [AW-1:0] LO = 32'h0000_1000;
  localparam logic [AW-1:0] HI = 32'h8000_2000;

  logic clk = 0, rst_n = 0;
  logic m0_req = 0, m1_req = 0;
  logic [AW-1:0] m0_addr = LO, m1_addr = HI;
  logic [DW-1:0] m0_wdata = 32'hA0A0_0001, m1_wdata = 32'hB1B1_0002;
  logic [CW-1:0] m0_ctrl = 4'h3, m1_ctrl = 4'hC;
  logic ch0_vld, ch1_vld, m0_gnt, m1_gnt, sw_sel;
  logic [AW-1:0] ch0_addr, ch1_addr;
  logic [DW-1:0] ch0_data, ch1_data;
  logic [CW-1:0] ch0_ctrl, ch1_ctrl;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic g0; logic g1; logic sw; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  dual_xbar_arb #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .m0_req(m0_req), .m0_addr(m0_addr), .m0_wdata(m0_wdata), .m0_ctrl(m0_ctrl),
    .m1_req(m1_req), .m1_addr(m1_addr), .m1_wdata(m1_wdata), .m1_ctrl(m1_ctrl),
    .ch0_vld(ch0_vld), .ch0_addr(ch0_addr), .ch0_data(ch0_data), .ch0_ctrl(ch0_ctrl),
    .ch1_vld(ch1_vld), .ch1_addr(ch1_addr), .ch1_data(ch1_data), .ch1_ctrl(ch1_ctrl),
    .m0_gnt(m0_gnt), .m1_gnt(m1_gnt), .sw_sel(sw_sel)
  );

  task automatic compare(input exp_t e);
    logic [AW-1:0] a0, a1;
    logic [DW-1:0] d0, d1;
    logic [CW-1:0] k0, k1;
    logic v0, v1;
    a0 = e.sw ? m1_addr : m0_addr;   a1 = e.sw ? m0_addr : m1_addr;
    d0 = e.sw ? m1_wdata : m0_wdata; d1 = e.sw ? m0_wdata : m1_wdata;
    k0 = e.sw ? m1_ctrl : m0_ctrl;   k1 = e.sw ? m0_ctrl : m1_ctrl;
    v0 = e.sw ? e.g1 : e.g0;         v1 = e.sw ? e.g0 : e.g1;
    total++;
    if ({m0_gnt, m1_gnt, sw_sel} !== {e.g0, e.g1, e.sw}) begin
      bad++;
      $display("FAIL %s: gnt0/gnt1/sw got %b%b%b exp %b%b%b", e.tag, m0_gnt, m1_gnt, sw_sel, e.g0, e.g1, e.sw);
    end else if ({ch0_vld, ch1_vld, ch0_addr, ch1_addr, ch0_data, ch1_data, ch0_ctrl, ch1_ctrl}
                 !== {v0, v1, a0, a1, d0, d1, k0, k1}) begin
      bad++;
      $display("FAIL R3 (%s): ch0 %b %h %h %h ch1 %b %h %h %h exp ch0 %b %h %h %h ch1 %b %h %h %h",
               e.tag, ch0_vld, ch0_addr, ch0_data, ch0_ctrl, ch1_vld, ch1_addr, ch1_data, ch1_ctrl,
               v0, a0, d0, k0, v1, a1, d1, k1);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic drive(input logic r0, input logic [AW-1:0] a0, input logic r1, input logic [AW-1:0] a1,
                       input logic g0, input logic g1, input logic sw, input string tag);
    exp_t e;
    @(negedge clk);
    m0_req = r0; m0_addr = a0; m1_req = r1; m1_addr = a1;
    m0_wdata = m0_wdata + 32'h11; m1_ctrl = m1_ctrl ^ 4'h5;
    e.g0 = g0; e.g1 = g1; e.sw = sw; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    begin
      exp_t e;
      e.g0 = 0; e.g1 = 0; e.sw = 0; e.tag = "R1 reset";
      compare(e);
    end
    // R4 / R2 crossed parallel service
    drive(1, HI, 1, LO, 1, 1, 1, "R4 crossed parallel");
    drive(1, HI, 1, LO, 1, 1, 1, "R6 hold crossed");
    drive(0, HI, 0, LO, 0, 0, 1, "R6 release both");
    // R5 first collision: master 0 wins
    drive(1, LO, 1, LO, 1, 0, 0, "R5 collision m0 wins");
    drive(1, LO, 1, LO, 1, 0, 0, "R6 loser waits");
    drive(0, LO, 1, LO, 0, 1, 1, "R7 handover to m1");
    drive(0, LO, 0, LO, 0, 0, 1, "R6 idle keeps route");
    // R5 second collision: master 1 wins
    drive(1, HI, 1, HI, 0, 1, 0, "R5 collision m1 wins");
    drive(1, HI, 1, HI, 0, 1, 0, "R6 m0 waits");
    drive(1, HI, 0, HI, 1, 0, 1, "R7 handover to m0");
    drive(0, HI, 0, HI, 0, 0, 1, "R6 idle");
    // R9 late request for the free slave
    drive(1, LO, 0, HI, 1, 0, 0, "R2 single m0 straight");
    drive(1, LO, 1, HI, 1, 1, 0, "R9 join without reroute");
    drive(1, LO, 1, HI, 1, 1, 0, "R4 straight parallel hold");
    drive(0, LO, 0, HI, 0, 0, 0, "R6 release");
    // R5 third collision: master 0 again
    drive(1, HI, 1, HI, 1, 0, 1, "R5 alternation m0 again");
    drive(0, HI, 1, HI, 0, 1, 0, "R7 handover");
    drive(0, HI, 0, HI, 0, 0, 0, "R8 no request no grant");
    drive(0, LO, 1, LO, 0, 1, 1, "R2 single m1 crossed");
    drive(0, LO, 0, LO, 0, 0, 1, "R8 idle");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule